// File: doc/BRIEF.md
# NAND Flash Command Cycle Sequencer

This block carries out one NAND flash operation on the flash bus. The operation is given as a 16-bit command code. Each set bit of the code turns on one bus phase: opcode latch, address latch, data write from the internal buffer, a wait on a ready/busy line, data read into the buffer, or a single-byte status or four-byte ID capture. A single code therefore describes a reset, a status poll, a page program or a page read. The sequencer walks the enabled phases from the highest bit to the lowest and skips the clear ones without touching the bus.

Up to three opcodes, a 16-bit column register, a 32-bit row register and a byte count are captured at the start strobe. The row register also carries the chip to enable and the ready/busy line to watch. Data moves through a buffer of 32-bit words. The first NAND byte lands in the most significant byte of word 0. The host fills and reads the buffer through a simple word port while the sequencer is idle.

Top module: `nand_cmd_seq`

## Requirements
- R1: Enabled phases run strictly from code bit 14 down to bit 2. A clear bit causes no bus cycle, and bits 15, 1 and 0 are ignored.
- R2: Opcode phases are bit 14 (`opc1`), bit 7 (`opc2`) and bit 4 (`opc3`). Each is one bus cycle with `nand_cle` high, `nand_ale` low and the opcode on `nand_dq_o`. In that cycle `nand_we_n` is low for one clock and then high for one clock.
- R3: Address phases are bit 13 `col_addr[7:0]`, bit 12 `col_addr[15:8]`, bit 11 `row_addr[7:0]`, bit 10 `row_addr[15:8]` and bit 9 `row_addr[23:16]`. Each is one `nand_we_n` cycle with `nand_ale` high and `nand_cle` low. A run of N bits downward from bit 13 sends N address bytes.
- R4: Bit 8 writes `byte_cnt` bytes with `nand_we_n` cycles. Byte i is taken from buffer word i/4, bits [31-8·(i mod 4) -: 8]. A count of zero produces no cycle.
- R5: Bit 5 reads `byte_cnt` bytes. Each byte is one `nand_re_n` low/high cycle, and `nand_dq_i` is sampled as `nand_re_n` rises. Read byte i is stored big-endian at the same buffer position as in R4.
- R6: Bit 6 holds the sequence until the ready/busy line given by `row_addr[31:28]` is high. During the wait there are no strobes.
- R7: If that line stays low for `rb_timeout` consecutive clocks, `timeout_err` is set, the remaining phases are dropped and the operation ends with `done`. `timeout_err` clears at the next start.
- R8: Bit 3 captures one read cycle into `status_byte`. Bit 2 captures four read cycles into `id_word`, with the first byte at bits 31:24.
- R9: While busy, exactly the `nand_ce_n` line given by `row_addr[27:24]` is low. While idle, all lines are high.
- R10: `start` while idle launches the operation and raises `busy`. `done` is a one-clock pulse in the cycle `busy` falls. A `start` while busy is ignored.
- R11: Host buffer writes (`buf_we`) take effect only while idle. While busy they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe |
| cmd_code | input | 16 | Phase-enable code |
| opc1 | input | 8 | Opcode for bit 14 |
| opc2 | input | 8 | Opcode for bit 7 |
| opc3 | input | 8 | Opcode for bit 4 |
| col_addr | input | 16 | Column address bytes |
| row_addr | input | 32 | Row bytes [23:0], chip [27:24], ready/busy line [31:28] |
| byte_cnt | input | CNT_W | Bytes for the write or read data phase |
| rb_timeout | input | TMO_W | Wait limit in clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| timeout_err | output | 1 | Last wait timed out |
| status_byte | output | 8 | Captured status byte |
| id_word | output | 32 | Captured ID bytes, big-endian |
| buf_we | input | 1 | Host buffer word write |
| buf_addr | input | BUF_AW | Host buffer word address |
| buf_wdata | input | 32 | Host buffer write data |
| buf_rdata | output | 32 | Buffer word at buf_addr |
| nand_ce_n | output | NCHIP | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_n | input | NCHIP | Ready/busy lines, high when ready |

## Verification
The bound checker watches the strobe rules on every cycle. It checks that CLE and ALE are never high together and that WE# and RE# are never low together, that RE# only moves while busy, and that exactly one chip enable is low while busy and none while idle. It also checks that `done` is a single pulse that coincides with `busy` falling, and that a timeout always ends the operation. The order of phases, the address and data bytes, the big-endian buffer packing, the status and ID capture, the wait length and the ignored start and ignored buffer writes can only be shown by the bench. Its flash model logs every strobe edge and compares the log with a sequence rebuilt from the command code.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int BUF_WORDS = 16,
  parameter int NCHIP     = 4,
  parameter int TMO_W     = 16,
  parameter int BUF_AW    = $clog2(BUF_WORDS),
  parameter int CNT_W     = BUF_AW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       cmd_code,
  input  logic [7:0]        opc1,
  input  logic [7:0]        opc2,
  input  logic [7:0]        opc3,
  input  logic [15:0]       col_addr,
  input  logic [31:0]       row_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [TMO_W-1:0]  rb_timeout,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [7:0]        status_byte,
  output logic [31:0]       id_word,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [31:0]       buf_wdata,
  output logic [31:0]       buf_rdata,
  output logic [NCHIP-1:0]  nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic [NCHIP-1:0]  nand_rb_n
);
  localparam int SELW = (NCHIP > 1) ? $clog2(NCHIP) : 1;

  logic [31:0]      mem [BUF_WORDS];
  logic [14:2]      pend;
  logic             ph;
  logic [CNT_W-1:0] bcnt;
  logic [TMO_W-1:0] tcnt;
  logic [7:0]       c_op1, c_op2, c_op3;
  logic [15:0]      c_col;
  logic [31:0]      c_row;
  logic [CNT_W-1:0] c_cnt;
  logic [TMO_W-1:0] c_tmo;
  logic [3:0]       cur;
  logic             is_cmd, is_adr, is_wr, is_rd, zero_len, rb_ok, strobe;
  logic [TMO_W:0]   tcnt_n;
  logic [BUF_AW-1:0] bw;

  always_comb begin
    cur = '0;
    for (int i = 2; i <= 14; i++)
      if (pend[i]) cur = 4'(i);
  end

  assign is_cmd   = (cur == 4'd14) || (cur == 4'd7) || (cur == 4'd4);
  assign is_adr   = (cur >= 4'd9) && (cur <= 4'd13);
  assign is_wr    = (cur == 4'd8);
  assign is_rd    = (cur == 4'd5) || (cur == 4'd3) || (cur == 4'd2);
  assign zero_len = ((cur == 4'd8) || (cur == 4'd5)) && (c_cnt == '0);
  assign strobe   = busy && !ph && !zero_len;
  assign rb_ok    = nand_rb_n[c_row[28 +: SELW]];
  assign bw       = bcnt[BUF_AW+1:2];
  assign tcnt_n   = {1'b0, tcnt} + 1'b1;

  assign nand_cle   = busy && is_cmd;
  assign nand_ale   = busy && is_adr;
  assign nand_we_n  = !(strobe && (is_cmd || is_adr || is_wr));
  assign nand_re_n  = !(strobe && is_rd);
  assign nand_dq_oe = busy && (is_cmd || is_adr || is_wr);
  assign nand_ce_n  = busy ? ~(NCHIP'(1) << c_row[24 +: SELW]) : '1;
  assign buf_rdata  = mem[buf_addr];

  always_comb begin
    unique case (cur)
      4'd14:   nand_dq_o = c_op1;
      4'd7:    nand_dq_o = c_op2;
      4'd4:    nand_dq_o = c_op3;
      4'd13:   nand_dq_o = c_col[7:0];
      4'd12:   nand_dq_o = c_col[15:8];
      4'd11:   nand_dq_o = c_row[7:0];
      4'd10:   nand_dq_o = c_row[15:8];
      4'd9:    nand_dq_o = c_row[23:16];
      4'd8:    nand_dq_o = mem[bw][{~bcnt[1:0], 3'b000} +: 8];
      default: nand_dq_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!busy && buf_we)
      mem[buf_addr] <= buf_wdata;
    else if (busy && cur == 4'd5 && strobe)
      mem[bw][{~bcnt[1:0], 3'b000} +: 8] <= nand_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; timeout_err <= 1'b0;
      pend <= '0; ph <= 1'b0; bcnt <= '0; tcnt <= '0;
      c_op1 <= '0; c_op2 <= '0; c_op3 <= '0; c_col <= '0; c_row <= '0;
      c_cnt <= '0; c_tmo <= '0; status_byte <= '0; id_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; timeout_err <= 1'b0;
          pend <= cmd_code[14:2]; ph <= 1'b0; bcnt <= '0; tcnt <= '0;
          c_op1 <= opc1; c_op2 <= opc2; c_op3 <= opc3;
          c_col <= col_addr; c_row <= row_addr; c_cnt <= byte_cnt; c_tmo <= rb_timeout;
        end
      end else if (pend == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        case (cur)
          4'd6: begin
            if (rb_ok) begin
              pend[6] <= 1'b0;
              tcnt <= '0;
            end else if (tcnt_n >= {1'b0, c_tmo}) begin
              timeout_err <= 1'b1; busy <= 1'b0; done <= 1'b1; pend <= '0;
            end else begin
              tcnt <= tcnt_n[TMO_W-1:0];
            end
          end
          4'd8, 4'd5: begin
            if (zero_len) pend[cur] <= 1'b0;
            else if (!ph) ph <= 1'b1;
            else begin
              ph <= 1'b0;
              if (bcnt == c_cnt - 1'b1) begin bcnt <= '0; pend[cur] <= 1'b0; end
              else bcnt <= bcnt + 1'b1;
            end
          end
          4'd3: begin
            if (!ph) begin ph <= 1'b1; status_byte <= nand_dq_i; end
            else begin ph <= 1'b0; pend[3] <= 1'b0; end
          end
          4'd2: begin
            if (!ph) begin ph <= 1'b1; id_word[{~bcnt[1:0], 3'b000} +: 8] <= nand_dq_i; end
            else begin
              ph <= 1'b0;
              if (bcnt[1:0] == 2'd3) begin bcnt <= '0; pend[2] <= 1'b0; end
              else bcnt <= bcnt + 1'b1;
            end
          end
          default: begin
            if (!ph) ph <= 1'b1;
            else begin ph <= 1'b0; pend[cur] <= 1'b0; end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int NCHIP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             timeout_err,
  input logic [NCHIP-1:0] nand_ce_n,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_we_n,
  input logic             nand_re_n
);
  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  a_r5_re_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> busy);
  a_r9_idle_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&nand_ce_n));
  a_r9_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~nand_ce_n) == 1));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (done && !busy));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.NCHIP(NCHIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout_err(timeout_err),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n)
);

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;
  localparam int BUF_WORDS = 16, NCHIP = 4, TMO_W = 16, BUF_AW = 4, CNT_W = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] cmd_code = '0;
  logic [7:0]  opc1 = 8'h70, opc2 = 8'h30, opc3 = 8'h10;
  logic [15:0] col_addr = '0;
  logic [31:0] row_addr = '0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic [TMO_W-1:0] rb_timeout = 16'd1000;
  logic busy, done, timeout_err;
  logic [7:0] status_byte;
  logic [31:0] id_word;
  logic buf_we = 1'b0;
  logic [BUF_AW-1:0] buf_addr = '0;
  logic [31:0] buf_wdata = '0, buf_rdata;
  logic [NCHIP-1:0] nand_ce_n, nand_rb_n;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_o, nand_dq_i;

  always #4 clk = ~clk;

  nand_cmd_seq #(.BUF_WORDS(BUF_WORDS), .NCHIP(NCHIP), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
    .opc1(opc1), .opc2(opc2), .opc3(opc3), .col_addr(col_addr), .row_addr(row_addr),
    .byte_cnt(byte_cnt), .rb_timeout(rb_timeout), .busy(busy), .done(done),
    .timeout_err(timeout_err), .status_byte(status_byte), .id_word(id_word),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n));

  int errors = 0, checks = 0;
  int ev_kind [512];
  logic [7:0] ev_val [512];
  int nev = 0, rd_idx = 0, rb_cnt = 0, rb_delay = 0, rb_line = 0, ce_bad = 0, cyc = 0;
  logic pwe = 1'b1, pre = 1'b1;
  logic [3:0] exp_chip = '0;
  logic [7:0] sh [64];

  function automatic logic [7:0] rdbyte(int n);
    return 8'(n * 37 + 11);
  endfunction

  assign nand_dq_i = rdbyte(rd_idx);
  always_comb begin
    nand_rb_n = '1;
    if (rb_cnt > 0) nand_rb_n[rb_line] = 1'b0;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: actual=%0d expected<150000", cyc);
      finish_run();
    end
    if (rb_cnt > 0) rb_cnt--;
    if (!pwe && nand_we_n && nev < 512) begin
      ev_kind[nev] = nand_cle ? 0 : (nand_ale ? 1 : 2);
      ev_val[nev] = nand_dq_o;
      nev++;
      if (nand_cle) rb_cnt = rb_delay;
    end
    if (!pre && nand_re_n && nev < 512) begin
      ev_kind[nev] = 3; ev_val[nev] = rdbyte(rd_idx); nev++; rd_idx++;
    end
    if (busy && nand_ce_n != ~(4'b0001 << exp_chip[1:0])) ce_bad++;
    pwe = nand_we_n; pre = nand_re_n;
  end

  task automatic load_buf();
    for (int w = 0; w < BUF_WORDS; w++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = 4'(w); buf_wdata = $urandom;
      {sh[4*w], sh[4*w+1], sh[4*w+2], sh[4*w+3]} = buf_wdata;
    end
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic check_buf(string req);
    for (int w = 0; w < BUF_WORDS; w++) begin
      buf_addr = 4'(w); #1;
      chk(buf_rdata == {sh[4*w], sh[4*w+1], sh[4*w+2], sh[4*w+3]}, req, "buffer word",
          buf_rdata, {sh[4*w], sh[4*w+1], sh[4*w+2], sh[4*w+3]});
    end
  endtask

  // inject: 0 none, 1 extra start and host write while busy
  task automatic run_op(logic [15:0] code, int cnt, int chip, int rbl, int dly,
                        int tmo, bit exp_to, int inject, output int ncyc);
    int ek [512];
    logic [7:0] evx [512];
    int ne = 0, rbase, rj = 0, to_stop;
    logic [7:0] exp_stat;
    logic [31:0] exp_id;
    bit seen_done = 0;
    exp_stat = status_byte; exp_id = id_word;
    cmd_code = code; byte_cnt = CNT_W'(cnt); rb_timeout = TMO_W'(tmo);
    col_addr = 16'($urandom); row_addr = {4'(rbl), 4'(chip), 24'($urandom)};
    rb_delay = dly; rb_line = rbl; rb_cnt = 0; exp_chip = 4'(chip);
    nev = 0; ce_bad = 0; rbase = rd_idx;
    to_stop = exp_to && code[6];
    for (int b = 14; b >= 2; b--) begin
      if (!code[b]) continue;
      if (to_stop && b < 6) break;
      case (b)
        14: begin ek[ne] = 0; evx[ne] = opc1; ne++; end
        7:  begin ek[ne] = 0; evx[ne] = opc2; ne++; end
        4:  begin ek[ne] = 0; evx[ne] = opc3; ne++; end
        13: begin ek[ne] = 1; evx[ne] = col_addr[7:0]; ne++; end
        12: begin ek[ne] = 1; evx[ne] = col_addr[15:8]; ne++; end
        11: begin ek[ne] = 1; evx[ne] = row_addr[7:0]; ne++; end
        10: begin ek[ne] = 1; evx[ne] = row_addr[15:8]; ne++; end
        9:  begin ek[ne] = 1; evx[ne] = row_addr[23:16]; ne++; end
        8:  for (int i = 0; i < cnt; i++) begin ek[ne] = 2; evx[ne] = sh[i]; ne++; end
        5:  for (int i = 0; i < cnt; i++) begin
              ek[ne] = 3; evx[ne] = rdbyte(rbase + rj); sh[i] = evx[ne]; rj++; ne++;
            end
        3:  begin ek[ne] = 3; evx[ne] = rdbyte(rbase + rj); exp_stat = evx[ne]; rj++; ne++; end
        2:  for (int i = 0; i < 4; i++) begin
              ek[ne] = 3; evx[ne] = rdbyte(rbase + rj); exp_id[31-8*i -: 8] = evx[ne]; rj++; ne++;
            end
        default: ;
      endcase
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ncyc = 1;
    for (int k = 0; k < 5000 && !seen_done; k++) begin
      @(negedge clk);
      ncyc++;
      if (done) seen_done = 1;
      if (inject == 1 && k == 3) begin
        start = 1'b1; cmd_code = 16'h7FC8; buf_we = 1'b1; buf_addr = '0; buf_wdata = 32'hDEADBEEF;
      end
      if (inject == 1 && k == 4) begin start = 1'b0; buf_we = 1'b0; end
    end
    chk(seen_done, "R10", "done seen", 32'(seen_done), 1);
    chk(nev == ne, "R1", "bus cycle count", 32'(nev), 32'(ne));
    for (int i = 0; i < ne && i < nev; i++) begin
      string rq;
      rq = (ek[i] == 0) ? "R2" : (ek[i] == 1) ? "R3" : (ek[i] == 2) ? "R4" : "R5";
      chk(ev_kind[i] == ek[i] && ev_val[i] == evx[i], rq, "bus cycle kind/value",
          {ev_kind[i][7:0], ev_val[i]}, {ek[i][7:0], evx[i]});
    end
    chk(timeout_err == exp_to, "R7", "timeout flag", 32'(timeout_err), 32'(exp_to));
    chk(ce_bad == 0, "R9", "chip enable mismatches", 32'(ce_bad), 0);
    if (code[3] && !to_stop) chk(status_byte == exp_stat, "R8", "status byte", 32'(status_byte), 32'(exp_stat));
    if (code[2] && !to_stop) chk(id_word == exp_id, "R8", "ID word", id_word, exp_id);
    if (code[5] && !to_stop) check_buf("R5");
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    #20;
    chk(busy == 0 && done == 0 && timeout_err == 0, "R10", "reset flags", {busy, done, timeout_err}, 0);
    chk(nand_ce_n == 4'hF, "R9", "reset chip enables", 32'(nand_ce_n), 32'hF);
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R2", "reset strobes",
        {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
    rst_n = 1'b1;
    load_buf();
    check_buf("R11");
    // R6: reset code waits on line 2 for 30 clocks
    run_op(16'h4040, 0, 1, 2, 30, 1000, 0, 0, n);
    chk(n >= 30, "R6", "wait length", 32'(n), 30);
    // R1: reserved bits ignored
    run_op(16'hC043, 0, 3, 0, 3, 1000, 0, 0, n);
    run_op(16'h4068, 0, 0, 1, 4, 1000, 0, 0, n);
    run_op(16'h4068, 4, 2, 3, 2, 1000, 0, 0, n);
    run_op(16'h6004, 0, 1, 0, 0, 1000, 0, 0, n);
    run_op(16'h7FC8, 16, 2, 2, 6, 1000, 0, 0, n);
    run_op(16'h7EE0, 20, 3, 1, 5, 1000, 0, 0, n);
    run_op(16'h7FC8, 20, 0, 0, 2, 1000, 0, 0, n);
    run_op(16'h6190, 0, 1, 1, 0, 1000, 0, 0, n);
    // R7: stuck line times out
    run_op(16'h4068, 8, 2, 2, 100000, 25, 1, 0, n);
    chk(n < 60, "R7", "timeout length", 32'(n), 60);
    rb_delay = 0;
    run_op(16'h4068, 0, 0, 0, 0, 1000, 0, 0, n);
    chk(timeout_err == 0, "R7", "flag cleared", 32'(timeout_err), 0);
    // R10 and R11: start and buffer write while busy are ignored
    run_op(16'h4040, 0, 1, 1, 20, 1000, 0, 1, n);
    repeat (4) @(negedge clk);
    chk(busy == 0 && nev == 1, "R10", "no second operation", {busy, 8'(nev)}, 9'd1);
    check_buf("R11");
    for (int t = 0; t < 40; t++) begin
      run_op(16'($urandom) & 16'h7FFC, int'($urandom % 21), int'($urandom % 4),
             int'($urandom % 4), int'($urandom % 8), 1000, 0, 0, n);
    end
    finish_run();
  end
endmodule